// File: doc/BRIEF.md
# Pin Edge Interrupt Controller

This block watches a group of general-purpose port pins for edges and raises one combined interrupt request toward the processor. Each pin passes through a synchronizer. An edge detector then compares the pin's two most recent synchronized samples. A per-pin polarity bit selects whether a rising or a falling transition counts as active. An active edge sets a sticky per-pin flag. The flag stays set until software writes a one to that flag position.

A per-pin enable mask decides which flags feed the interrupt request. A flag records its edge whether or not its pin is enabled, so enabling a pin later with a pending flag raises the request at once. Software reaches the three registers over a plain synchronous bus with an address, a write strobe, write data and registered read data. Every register can be read and written at any time.

Top module: `pin_edge_irq`

## Requirements
- R1: After reset the enable, flag and polarity registers are all zero, and `irq` and `rdata` are 0.
- R2: Address 0 selects the enable mask, address 1 the flags and address 2 the polarity bits. `rdata` shows the register addressed at a clock edge from that edge onward. Address 3 reads as zero, and writes to address 3 change nothing.
- R3: A polarity bit of 1 makes a low-to-high pin transition active, and a 0 makes a high-to-low transition active. When the pin changes before clock edge k, its flag reads 1 after edge k+2.
- R4: A transition in the direction that the pin's polarity bit does not select leaves that pin's flag at 0.
- R5: Writing address 1 clears each flag bit whose write-data bit is 1. Flag bits whose write-data bit is 0 keep their value.
- R6: A flag is set by an active edge even while that pin's enable bit is 0.
- R7: `irq` is active high. It equals the OR over all pins of (flag AND enable) as those values stood one clock earlier.
- R8: If an active edge and a clearing write reach the same flag bit at the same clock edge, the flag ends up 1.
- R9: Writing a polarity bit does not set a flag by itself. The next transition after the write is judged under the new polarity.
- R10: A write to the enable or polarity address stores all eight data bits, and a later read returns them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pins | input | 8 | Asynchronous pin levels |
| we | input | 1 | Write strobe for the register bus |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Combined interrupt request, active high |

## Verification
The bench uses the default build: eight pins and a two-stage synchronizer. With eight pins, the upper half of the pins can be set to rising polarity and the lower half to falling polarity, so one pattern change hits both detector directions at once and also produces the wrong-direction case on the reverse change. The two-stage depth sets the three-edge flag delay and the four-edge request delay that the bench counts. That fixed timing lets the bench place a clearing write on exactly the same edge as a new active edge, which is the collision case.

// File: rtl/pei_pkg.sv
// Shared definitions for the pin edge interrupt controller.
// Assumes a two-bit register address space with one register per address.
package pei_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_MASK = 2'd0,
        SEL_FLAG = 2'd1,
        SEL_POL  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/pei_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pin inputs.
// Assumes every bit is independent; no bus coherency is implied.
module pei_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= '0;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                // Later stages resample the previous stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pei_edge.sv
// Per-pin edge detector with selectable polarity.
// Assumes a synchronized input; history is kept across polarity changes.
module pei_edge #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] rise_sel,
    output logic [WIDTH-1:0] hit
);
    logic [WIDTH-1:0] prev_q;

    // Holds the previous synchronized sample of each pin.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_pin
            // Picks the transition direction this pin counts as active.
            always_comb begin
                if (rise_sel[i]) hit[i] = level[i] & ~prev_q[i];
                else             hit[i] = ~level[i] & prev_q[i];
            end
        end
    endgenerate
endmodule

// File: rtl/pei_regs.sv
// Register file: enable mask, polarity select and sticky write-one-clear flags.
// Assumes one access per cycle; read data is registered.
module pei_regs
    import pei_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [WIDTH-1:0]  hit,
    output logic [WIDTH-1:0]  mask_q,
    output logic [WIDTH-1:0]  pol_q,
    output logic [WIDTH-1:0]  flag_q,
    output logic [WIDTH-1:0]  rdata_q
);
    logic             wr_mask;
    logic             wr_pol;
    logic [WIDTH-1:0] clr_bits;
    logic [WIDTH-1:0] rd_mux;

    // Decodes the write strobe into per-register enables.
    always_comb begin
        wr_mask  = we && (addr == SEL_MASK);
        wr_pol   = we && (addr == SEL_POL);
        clr_bits = (we && (addr == SEL_FLAG)) ? wdata : '0;
    end

    // Selects the register presented on the read port.
    always_comb begin
        case (addr)
            SEL_MASK: rd_mux = mask_q;
            SEL_FLAG: rd_mux = flag_q;
            SEL_POL:  rd_mux = pol_q;
            default:  rd_mux = '0;
        endcase
    end

    // Updates mask and polarity on their writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            pol_q  <= '0;
        end else begin
            if (wr_mask) mask_q <= wdata;
            if (wr_pol)  pol_q  <= wdata;
        end
    end

    // Sticky flags: a new edge wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_bits) | hit;
    end

    // Registers the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rd_mux;
    end
endmodule

// File: rtl/pei_irq.sv
// Combines masked flags into one registered, active-high request.
// Assumes the flag and mask vectors come from the same clock domain.
module pei_irq #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] flags,
    input  logic [WIDTH-1:0] mask,
    output logic             irq_q
);
    // Registers the OR of the enabled flags.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(flags & mask);
    end
endmodule

// File: rtl/pin_edge_irq.sv
// Top level of the pin edge interrupt controller.
// Assumes pins are asynchronous and the bus is synchronous to clk.
module pin_edge_irq
    import pei_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0] rdata,
    output logic                irq
);
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] edge_hit;
    logic [NUM_PINS-1:0] mask_q;
    logic [NUM_PINS-1:0] pol_q;
    logic [NUM_PINS-1:0] flag_q;

    pei_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(pins), .sync_out(pin_sync)
    );

    pei_edge #(.WIDTH(NUM_PINS)) edge_i (
        .clk(clk), .rst_n(rst_n), .level(pin_sync), .rise_sel(pol_q), .hit(edge_hit)
    );

    pei_regs #(.WIDTH(NUM_PINS)) regs_i (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
        .hit(edge_hit), .mask_q(mask_q), .pol_q(pol_q), .flag_q(flag_q),
        .rdata_q(rdata)
    );

    pei_irq #(.WIDTH(NUM_PINS)) irq_i (
        .clk(clk), .rst_n(rst_n), .flags(flag_q), .mask(mask_q), .irq_q(irq)
    );
endmodule

// File: rtl/pei_chk.sv
// Property checker for the pin edge interrupt controller, bound to the top.
// Assumes it observes the bus ports and the internal flag, mask and edge vectors.
module pei_chk
    import pei_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [W-1:0]      wdata,
    input logic [W-1:0]      flags,
    input logic [W-1:0]      mask,
    input logic [W-1:0]      edge_hit,
    input logic              irq
);
    logic [W-1:0] clr_req;
    assign clr_req = (we && addr == SEL_FLAG) ? wdata : '0;

    AST_FLAG_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(edge_hit)) == '0)); // R3

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & $past(clr_req) & ~$past(edge_hit)) == '0)); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(flags) & ~$past(clr_req) & ~flags) == '0)); // R5

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(edge_hit) & ~flags) == '0)); // R8

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == |($past(flags) & $past(mask)))); // R7
endmodule

bind pin_edge_irq pei_chk #(.W(NUM_PINS)) chk_i (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .flags(flag_q), .mask(mask_q), .edge_hit(edge_hit), .irq(irq)
);

// File: tb/pin_edge_irq_tb.sv
module pin_edge_irq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pins = 8'h0F;
    logic       we = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    bit  rd_issue = 1'b0;
    bit  rd_pend = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;

    pin_edge_irq dut_i (
        .clk(clk), .rst_n(rst_n), .pins(pins), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always @(posedge clk) rd_pend <= rd_issue;

    // Monitor: pops the expected read value as the registered data appears.
    always @(negedge clk) begin
        if (rd_pend && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (rdata !== e) begin
                n_bad++;
                $display("FAIL %s rdata actual=%02h expected=%02h", t, rdata, e);
            end
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = 8'h00;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
        addr = a; rd_issue = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        rd_issue = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        n_chk++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s irq actual=%0b expected=%0b", t, irq, e);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        // R1: reset values
        chk_irq(1'b0, "R1");
        n_chk++;
        if (rdata !== 8'h00) begin
            n_bad++;
            $display("FAIL R1 rdata actual=%02h expected=00", rdata);
        end
        rst_n = 1'b1;
        rd(2'd0, 8'h00, "R1"); rd(2'd1, 8'h00, "R1"); rd(2'd2, 8'h00, "R1");
        tick(4);
        // R4: rising edges on bits 3:0 under falling polarity leave flags clear
        rd(2'd1, 8'h00, "R4");
        // R10: polarity stores all bits
        wr(2'd2, 8'hF0);
        rd(2'd2, 8'hF0, "R10");
        // R2: address 3 ignores writes and reads zero
        wr(2'd3, 8'hFF);
        rd(2'd3, 8'h00, "R2");
        rd(2'd0, 8'h00, "R2");
        rd(2'd2, 8'hF0, "R2");
        // R3/R6: both directions at once, enable all zero
        pins = 8'hF0;
        tick(2);
        rd(2'd1, 8'h00, "R3");   // latched before edge k+2
        rd(2'd1, 8'hFF, "R3");   // flag present after edge k+2
        tick(1);
        chk_irq(1'b0, "R6");
        rd(2'd1, 8'hFF, "R6");
        // R7: enabling a pending flag raises the request
        wr(2'd0, 8'h04);
        chk_irq(1'b0, "R7");
        tick(1);
        chk_irq(1'b1, "R7");
        // R5: write-one clears, write-zero keeps
        wr(2'd1, 8'h04);
        tick(1);
        chk_irq(1'b0, "R7");
        rd(2'd1, 8'hFB, "R5");
        wr(2'd1, 8'h00);
        rd(2'd1, 8'hFB, "R5");
        // R4: reverse transitions do not set flags
        wr(2'd1, 8'hFF);
        pins = 8'h0F;
        tick(4);
        rd(2'd1, 8'h00, "R4");
        // R9: polarity write alone sets nothing; next edge uses new polarity
        wr(2'd2, 8'h0F);
        tick(3);
        rd(2'd1, 8'h00, "R9");
        pins = 8'h00;
        tick(4);
        rd(2'd1, 8'h00, "R9");
        pins = 8'h0F;
        tick(4);
        rd(2'd1, 8'h0F, "R9");
        // R8: set wins over a same-edge clear on bit 0
        pins = 8'h0E;
        tick(4);
        pins = 8'h0F;
        tick(2);
        wr(2'd1, 8'h01);
        rd(2'd1, 8'h0F, "R8");
        wr(2'd1, 8'h01);
        rd(2'd1, 8'h0E, "R5");
        // R7/R10: full enable mask drives the request, clearing drops it
        wr(2'd0, 8'hFF);
        rd(2'd0, 8'hFF, "R10");
        chk_irq(1'b1, "R7");
        wr(2'd1, 8'hFF);
        tick(1);
        chk_irq(1'b0, "R7");
        rd(2'd1, 8'h00, "R5");
        tick(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule